// File: doc/BRIEF.md
# Refresh Slope PI Controller

This block tunes the slope of the proportional region of a memory controller's refresh idle-delay curve. A refresh that has been postponed many times should be sent with little idle delay. A refresh that has been postponed only a few times can wait longer. The slope sets how quickly that waiting time shrinks as the backlog grows. The aim is for refreshes to be spread evenly over the whole allowed postponement range, instead of collecting at one end of it.

Every time the scheduler issues a refresh, the block compares the current backlog with a pivot threshold. It counts the issue as "low" when the backlog is below the pivot and as "high" otherwise. The imbalance between the two counts drives a proportional-integral loop, and the result is the slope. The proportional and integral weights are arithmetic right-shift amounts, so the block needs no multipliers. When either count is about to overflow, both counts are halved, which keeps their ratio. The idle-delay curve itself lies outside this block; the block only produces the slope that the curve uses.

Top module: `refresh_slope_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, both tallies and the integral are cleared and `slope` loads `init_slope`.
- R2: A refresh pulse sampled at an edge adds one to the low tally when `backlog < pivot` (unsigned) and to the high tally otherwise. A backlog equal to the pivot counts as high.
- R3: When the increment would carry out of a CNT_W-bit tally, both tallies are halved (shift right by one, with the increment included). For example, a low tally at 63 that receives one more low sample becomes 32 when CNT_W is 6.
- R4: The error is the low tally minus the high tally. The integral adds the error once for each refresh pulse and saturates at the signed INT_W limits.
- R5: On update, `slope` becomes `(err >>> p_shift) + (integral >>> i_shift)`, using arithmetic shifts. The error and the integral are the values that already include the current pulse.
- R6: The slope sum is clamped to the range 0 to 2^SLOPE_W-1.
- R7: The tallies change at the edge that samples the refresh pulse. `slope` changes at the following edge. With no pulse, `slope` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_issued | input | 1 | One-cycle pulse for each refresh issued |
| backlog | input | BL_W | Current count of postponed refreshes |
| pivot | input | BL_W | Threshold that splits low from high samples |
| p_shift | input | SH_W | Proportional weight as a right-shift amount |
| i_shift | input | SH_W | Integral weight as a right-shift amount |
| init_slope | input | SLOPE_W | Slope loaded during reset |
| slope | output | SLOPE_W | Registered slope value |

## Verification
A table of mixed low and high samples, applied under several shift weights, checks that the slope follows the PI sum. That table also shows whether a backlog equal to the pivot is classed as high. A long run of low samples pushes a tally past its limit, which separates correct halving from wrap-around. A longer run of low samples, with a small integral shift, tells a saturating integral apart from one that wraps negative. Runs of all-high samples, and an integral shift of zero, reach the lower and upper slope clamps.

// File: rtl/rslope_pkg.sv
package rslope_pkg;
  typedef enum logic {SIDE_LOW = 1'b0, SIDE_HIGH = 1'b1} side_e;
  localparam int NSIDES = 2;
endpackage

// File: rtl/rslope_tally.sv
module rslope_tally
  import rslope_pkg::*;
#(
  parameter int BL_W  = 4,
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hit,
  input  logic [BL_W-1:0]  backlog,
  input  logic [BL_W-1:0]  pivot,
  output logic [CNT_W-1:0] lo_cnt,
  output logic [CNT_W-1:0] hi_cnt,
  output logic             upd
);
  localparam logic [CNT_W-1:0] HALF = CNT_W'(1) << (CNT_W - 1);

  side_e            side;
  logic [CNT_W-1:0] cnt     [NSIDES];
  logic [CNT_W-1:0] cnt_nxt [NSIDES];
  logic [CNT_W:0]   wide    [NSIDES];
  logic [NSIDES-1:0] cout;
  logic             carry;

  assign side = (backlog < pivot) ? SIDE_LOW : SIDE_HIGH;

  for (genvar s = 0; s < NSIDES; s++) begin : g_side
    assign wide[s] = {1'b0, cnt[s]} + {{CNT_W{1'b0}}, (side == side_e'(s))};
    assign cout[s] = wide[s][CNT_W];
    assign cnt_nxt[s] = carry ? wide[s][CNT_W:1] : wide[s][CNT_W-1:0];
  end

  assign carry = |cout;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < NSIDES; s++) cnt[s] <= '0;
      upd <= 1'b0;
    end else begin
      upd <= hit;
      if (hit) begin
        for (int s = 0; s < NSIDES; s++) cnt[s] <= cnt_nxt[s];
      end
    end
  end

  assign lo_cnt = cnt[SIDE_LOW];
  assign hi_cnt = cnt[SIDE_HIGH];

  logic [CNT_W:0] total;
  assign total = {1'b0, lo_cnt} + {1'b0, hi_cnt};

  // R2
  tally_step_chk: assert property (@(posedge clk) disable iff (rst)
    (hit && !carry) |=> (total == $past(total) + 1'b1));

  // R3
  tally_halve_chk: assert property (@(posedge clk) disable iff (rst)
    (hit && lo_cnt == {CNT_W{1'b1}} && backlog < pivot) |=> (lo_cnt == HALF));

  // R7
  tally_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !hit |=> ($stable(lo_cnt) && $stable(hi_cnt)));
endmodule

// File: rtl/rslope_integ.sv
module rslope_integ #(
  parameter int CNT_W = 6,
  parameter int INT_W = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    upd,
  input  logic signed [CNT_W:0]   err,
  output logic signed [INT_W-1:0] integ_q,
  output logic signed [INT_W-1:0] integ_nxt
);
  localparam logic signed [INT_W-1:0] IMAX = {1'b0, {(INT_W-1){1'b1}}};
  localparam logic signed [INT_W-1:0] IMIN = {1'b1, {(INT_W-1){1'b0}}};

  logic signed [INT_W:0] wide_sum;

  assign wide_sum = {integ_q[INT_W-1], integ_q}
                  + {{(INT_W-CNT_W){err[CNT_W]}}, err};

  always_comb begin
    if (wide_sum[INT_W] != wide_sum[INT_W-1])
      integ_nxt = wide_sum[INT_W] ? IMIN : IMAX;
    else
      integ_nxt = wide_sum[INT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) integ_q <= '0;
    else if (upd) integ_q <= integ_nxt;
  end

  // R4
  integ_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !upd |=> $stable(integ_q));

  // R4
  integ_mono_chk: assert property (@(posedge clk) disable iff (rst)
    (upd && err > 0) |=> (integ_q >= $past(integ_q)));
endmodule

// File: rtl/rslope_mix.sv
module rslope_mix #(
  parameter int CNT_W   = 6,
  parameter int INT_W   = 16,
  parameter int SLOPE_W = 12,
  parameter int SH_W    = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    upd,
  input  logic [SLOPE_W-1:0]      init_slope,
  input  logic signed [CNT_W:0]   err,
  input  logic signed [INT_W-1:0] integ_nxt,
  input  logic [SH_W-1:0]         p_shift,
  input  logic [SH_W-1:0]         i_shift,
  output logic [SLOPE_W-1:0]      slope_q
);
  logic signed [CNT_W:0]   p_term;
  logic signed [INT_W-1:0] i_term;
  logic signed [INT_W:0]   total;
  logic [SLOPE_W-1:0]      clamped;

  assign p_term = err >>> p_shift;
  assign i_term = integ_nxt >>> i_shift;
  assign total  = {{(INT_W-CNT_W){p_term[CNT_W]}}, p_term}
                + {i_term[INT_W-1], i_term};

  always_comb begin
    if (total[INT_W])
      clamped = '0;
    else if (|total[INT_W-1:SLOPE_W])
      clamped = '1;
    else
      clamped = total[SLOPE_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) slope_q <= init_slope;
    else if (upd) slope_q <= clamped;
  end

  // R7
  slope_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !upd |=> $stable(slope_q));

  // R6
  slope_floor_chk: assert property (@(posedge clk) disable iff (rst)
    (upd && err <= 0 && integ_nxt <= 0) |=> (slope_q == '0));
endmodule

// File: rtl/refresh_slope_ctrl.sv
module refresh_slope_ctrl #(
  parameter int BL_W    = 4,
  parameter int CNT_W   = 6,
  parameter int INT_W   = 16,
  parameter int SLOPE_W = 12,
  parameter int SH_W    = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ref_issued,
  input  logic [BL_W-1:0]    backlog,
  input  logic [BL_W-1:0]    pivot,
  input  logic [SH_W-1:0]    p_shift,
  input  logic [SH_W-1:0]    i_shift,
  input  logic [SLOPE_W-1:0] init_slope,
  output logic [SLOPE_W-1:0] slope
);
  logic [CNT_W-1:0]        lo_cnt;
  logic [CNT_W-1:0]        hi_cnt;
  logic                    upd;
  logic signed [CNT_W:0]   err;
  logic signed [INT_W-1:0] integ_q;
  logic signed [INT_W-1:0] integ_nxt;

  rslope_tally #(.BL_W(BL_W), .CNT_W(CNT_W)) tally_i (
    .clk(clk), .rst(rst), .hit(ref_issued), .backlog(backlog), .pivot(pivot),
    .lo_cnt(lo_cnt), .hi_cnt(hi_cnt), .upd(upd)
  );

  assign err = $signed({1'b0, lo_cnt}) - $signed({1'b0, hi_cnt});

  rslope_integ #(.CNT_W(CNT_W), .INT_W(INT_W)) integ_i (
    .clk(clk), .rst(rst), .upd(upd), .err(err),
    .integ_q(integ_q), .integ_nxt(integ_nxt)
  );

  rslope_mix #(.CNT_W(CNT_W), .INT_W(INT_W), .SLOPE_W(SLOPE_W), .SH_W(SH_W)) mix_i (
    .clk(clk), .rst(rst), .upd(upd), .init_slope(init_slope), .err(err),
    .integ_nxt(integ_nxt), .p_shift(p_shift), .i_shift(i_shift), .slope_q(slope)
  );

  // R1
  reset_load_chk: assert property (@(posedge clk)
    rst |=> (slope == $past(init_slope) && integ_q == '0 && lo_cnt == '0 && hi_cnt == '0));
endmodule

// File: tb/refresh_slope_ctrl_tb_top.sv
module refresh_slope_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ref_issued = 1'b0;
  logic [3:0] backlog = '0, pivot = '0, p_shift = '0, i_shift = '0;
  logic [11:0] init_slope = 12'd100;
  logic [11:0] slope;

  int checks = 0, errors = 0;
  int m_lo, m_hi, m_int, m_slope;

  always #10 clk = ~clk;

  refresh_slope_ctrl dut_i (
    .clk(clk), .rst(rst), .ref_issued(ref_issued), .backlog(backlog),
    .pivot(pivot), .p_shift(p_shift), .i_shift(i_shift),
    .init_slope(init_slope), .slope(slope)
  );

  // {backlog, pivot, p_shift, i_shift}
  localparam logic [15:0] VEC [12] = '{
    16'h2500, 16'h2500, 16'h7500, 16'h5501, 16'h1412, 16'h9812,
    16'h8800, 16'h0310, 16'h0310, 16'hF302, 16'h3421, 16'h0000
  };

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(int init);
    @(negedge clk);
    rst = 1'b1; ref_issued = 1'b0; init_slope = 12'(init);
    @(posedge clk); @(negedge clk);
    rst = 1'b0;
    m_lo = 0; m_hi = 0; m_int = 0; m_slope = init;
  endtask

  task automatic model(int bl, int pv, int ps, int is);
    int tot;
    if (bl < pv) m_lo++; else m_hi++;
    if (m_lo > 63 || m_hi > 63) begin m_lo = m_lo / 2; m_hi = m_hi / 2; end
    m_int = m_int + (m_lo - m_hi);
    if (m_int > 32767) m_int = 32767;
    if (m_int < -32768) m_int = -32768;
    tot = ((m_lo - m_hi) >>> ps) + (m_int >>> is);
    if (tot < 0) tot = 0;
    if (tot > 4095) tot = 4095;
    m_slope = tot;
  endtask

  task automatic pulse(int bl, int pv, int ps, int is);
    @(negedge clk);
    backlog = 4'(bl); pivot = 4'(pv); p_shift = 4'(ps); i_shift = 4'(is);
    ref_issued = 1'b1;
    @(negedge clk);
    ref_issued = 1'b0;
    @(negedge clk);
    model(bl, pv, ps, is);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset(100);
    chk("R1 reset slope", int'(slope), 100);
    repeat (5) @(negedge clk);
    chk("R7 hold without pulse", int'(slope), 100);

    // R7: slope unchanged one edge after the pulse, updated on the next
    @(negedge clk);
    backlog = 4'd1; pivot = 4'd5; p_shift = 4'd0; i_shift = 4'd15; ref_issued = 1'b1;
    @(negedge clk);
    ref_issued = 1'b0;
    chk("R7 slope not yet updated", int'(slope), 100);
    @(negedge clk);
    model(1, 5, 0, 15);
    chk("R7 slope updated", int'(slope), m_slope);

    // R2 R4 R5: vector walk
    for (int k = 0; k < 12; k++) begin
      pulse(int'(VEC[k][15:12]), int'(VEC[k][11:8]), int'(VEC[k][7:4]), int'(VEC[k][3:0]));
      chk("R5 R2 vector slope", int'(slope), m_slope);
    end

    // R3: tally saturation halves both
    do_reset(7);
    for (int k = 0; k < 63; k++) pulse(0, 8, 0, 15);
    chk("R3 before carry", int'(slope), 63);
    pulse(0, 8, 0, 15);
    chk("R3 halved", int'(slope), 32);
    pulse(9, 8, 0, 15);
    chk("R3 after halve high sample", int'(slope), m_slope);

    // R4: integral saturates rather than wraps
    do_reset(0);
    for (int k = 0; k < 1200; k++) pulse(0, 8, 15, 4);
    chk("R4 integral saturated", int'(slope), m_slope);
    chk("R4 integral saturated value", int'(slope), 2047);

    // R6: upper clamp
    pulse(0, 8, 0, 0);
    chk("R6 upper clamp", int'(slope), 4095);

    // R6: lower clamp
    do_reset(55);
    for (int k = 0; k < 4; k++) pulse(8, 8, 0, 0);
    chk("R6 lower clamp", int'(slope), 0);

    // R1: reset again from a nonzero state
    do_reset(321);
    chk("R1 reset reload", int'(slope), 321);
    pulse(2, 3, 0, 0);
    chk("R1 cleared state", int'(slope), 2);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule